// File: doc/BRIEF.md
# Accumulator Double-Row Group Address Generator

This block turns one accumulator-array operation request into the ordered list of accumulator row numbers that the operation must read and write. The array holds VL_BITS/8 rows. A request names one of four 32-bit select values through a 2-bit index, a 1-bit offset field and a group mode of either two or four groups. The block splits the row space into as many equal slices as there are groups. The slice width is the stride. It reduces the chosen select value, plus twice the offset field, modulo the stride. It then clears the low bit so the result lands on an even row.

From that base it walks each group in turn. For each group it emits an even row and then the odd row directly after it, and it jumps one stride between groups. Each row number leaves on a valid/ready stream with a last marker on the final one.

Back-pressure rules: while `row_valid` is high and `row_ready` is low, `row_idx` and `row_last` stay frozen. The stream advances only on a cycle where both are high. Any value of `row_ready` is legal at any time. `start` is a plain control pin, not a stream. It is honoured only when no row is pending. While a sequence is under way it is dropped without effect.

Top module: `acc_rowgen`

## Requirements
- R1: After reset, `row_valid` is low and stays low until a start is accepted.
- R2: A `start` sampled high at a clock edge while `row_valid` is low makes `row_valid` high after that edge, showing the first row.
- R3: The base row is ((W + 2*`off_bit`) mod 2^32) mod stride with bit 0 cleared. W is the 32-bit word in bits [32*k+31 : 32*k] of `sel_bank`, where k = `sel_idx`.
- R4: Rows = VL_BITS/8 (16 by default). With `quad_mode`=0 there are 2 groups and stride = Rows/2. With `quad_mode`=1 there are 4 groups and stride = Rows/4.
- R5: The sequence has 2*groups entries. Entry j equals base + (j/2)*stride + (j mod 2), emitted in increasing j.
- R6: `row_last` is high exactly on the final entry, and that entry is always an odd row.
- R7: While `row_valid` is high and `row_ready` is low, the next cycle keeps `row_valid` high and `row_idx` and `row_last` unchanged.
- R8: A `start` raised while `row_valid` is high is ignored. The running sequence continues unchanged and no extra sequence follows.
- R9: After the last entry is accepted, `row_valid` is low in the next cycle.
- R10: `sel_bank`, `sel_idx`, `off_bit` and `quad_mode` are sampled only at an accepted start. Changes during a sequence do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new sequence (ignored while busy) |
| sel_bank | input | 128 | Four 32-bit select values, word k at bits [32k+31:32k] |
| sel_idx | input | 2 | Chooses the select word |
| off_bit | input | 1 | Offset field, contributes 2*off_bit |
| quad_mode | input | 1 | 0: two groups, 1: four groups |
| row_valid | output | 1 | Row index is presented |
| row_ready | input | 1 | Consumer accepts the presented row |
| row_idx | output | 4 | Accumulator row number (log2(VL_BITS/8) bits) |
| row_last | output | 1 | Final row of the sequence |

## Verification
The assertions assume that `row_ready` may take any value, and that `start` can arrive at any cycle, including in the middle of a sequence. They assume nothing about the select words. The stimulus therefore toggles `row_ready` low on odd entries of some sequences. On other sequences it holds `start` high and scrambles every request input for the whole sequence, which puts both rules on the stall and busy paths under load. The select words include values next to 2^32, so that adding the offset wraps around, which the mask reduction must tolerate. The stimulus always lowers `start` before the final handshake, so it never arms a new request by accident.

// File: rtl/acc_rowgen_pkg.sv
package acc_rowgen_pkg;

  typedef enum logic {
    GRP_PAIR = 1'b0,
    GRP_QUAD = 1'b1
  } grp_mode_e;

  function automatic int rows_for_vl(input int vl_bits);
    return vl_bits / 8;
  endfunction

endpackage

// File: rtl/acc_rowgen_base.sv
module acc_rowgen_base
  import acc_rowgen_pkg::*;
#(
  parameter int SEL_W   = 32,
  parameter int NUM_SEL = 4,
  parameter int ROW_W   = 4
) (
  input  logic [NUM_SEL*SEL_W-1:0]   sel_bank,
  input  logic [$clog2(NUM_SEL)-1:0] sel_idx,
  input  logic                       off_bit,
  input  grp_mode_e                  mode,
  output logic [ROW_W-1:0]           base,
  output logic [ROW_W-1:0]           stride
);
  localparam int ROWS = 1 << ROW_W;

  logic [SEL_W-1:0] slot [NUM_SEL];
  logic [SEL_W-1:0] pick;
  logic [SEL_W-1:0] sum;
  logic [SEL_W-1:0] mask_full;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_slot
    assign slot[g] = sel_bank[g*SEL_W +: SEL_W];
  end

  always_comb begin
    pick      = slot[sel_idx];
    sum       = pick + {{(SEL_W-2){1'b0}}, off_bit, 1'b0};
    stride    = (mode == GRP_QUAD) ? ROW_W'(ROWS/4) : ROW_W'(ROWS/2);
    mask_full = {{(SEL_W-ROW_W){1'b0}}, stride - ROW_W'(1)};
    base      = ROW_W'(sum & mask_full) & ~ROW_W'(1);
  end
endmodule

// File: rtl/acc_rowgen_seq.sv
module acc_rowgen_seq
  import acc_rowgen_pkg::*;
#(
  parameter int MAX_GRP = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  grp_mode_e                  mode,
  input  logic                       ready,
  output logic                       valid,
  output logic [$clog2(MAX_GRP)-1:0] grp,
  output logic                       half,
  output logic                       last,
  output logic                       load
);
  localparam int GRP_W = $clog2(MAX_GRP);

  grp_mode_e        mode_q;
  logic [GRP_W-1:0] grp_end;

  always_comb begin
    load    = start && !valid;
    grp_end = (mode_q == GRP_QUAD) ? GRP_W'(MAX_GRP-1) : GRP_W'(MAX_GRP/2-1);
    last    = valid && half && (grp == grp_end);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      grp    <= '0;
      half   <= 1'b0;
      mode_q <= GRP_PAIR;
    end else if (load) begin
      valid  <= 1'b1;
      grp    <= '0;
      half   <= 1'b0;
      mode_q <= mode;
    end else if (valid && ready) begin
      if (last) begin
        valid <= 1'b0;
      end else if (half) begin
        half <= 1'b0;
        grp  <= grp + GRP_W'(1);
      end else begin
        half <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/acc_rowgen_emit.sv
module acc_rowgen_emit #(
  parameter int ROW_W = 4,
  parameter int GRP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] base_in,
  input  logic [ROW_W-1:0] stride_in,
  input  logic [GRP_W-1:0] grp,
  input  logic             half,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] base_q;
  logic [ROW_W-1:0] stride_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
    end else if (load) begin
      base_q   <= base_in;
      stride_q <= stride_in;
    end
  end

  always_comb begin
    row = base_q + ROW_W'(ROW_W'(grp) * stride_q) + {{(ROW_W-1){1'b0}}, half};
  end
endmodule

// File: rtl/acc_rowgen.sv
module acc_rowgen
  import acc_rowgen_pkg::*;
#(
  parameter int VL_BITS = 128,
  parameter int SEL_W   = 32,
  parameter int NUM_SEL = 4,
  parameter int MAX_GRP = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [NUM_SEL*SEL_W-1:0]            sel_bank,
  input  logic [$clog2(NUM_SEL)-1:0]          sel_idx,
  input  logic                                off_bit,
  input  logic                                quad_mode,
  output logic                                row_valid,
  input  logic                                row_ready,
  output logic [$clog2(rows_for_vl(VL_BITS))-1:0] row_idx,
  output logic                                row_last
);
  localparam int ROWS  = rows_for_vl(VL_BITS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int GRP_W = $clog2(MAX_GRP);

  grp_mode_e        mode_in;
  logic [ROW_W-1:0] base_c;
  logic [ROW_W-1:0] stride_c;
  logic [GRP_W-1:0] grp;
  logic             half;
  logic             load;

  assign mode_in = grp_mode_e'(quad_mode);

  acc_rowgen_base #(
    .SEL_W  (SEL_W),
    .NUM_SEL(NUM_SEL),
    .ROW_W  (ROW_W)
  ) u_base (
    .sel_bank(sel_bank),
    .sel_idx (sel_idx),
    .off_bit (off_bit),
    .mode    (mode_in),
    .base    (base_c),
    .stride  (stride_c)
  );

  acc_rowgen_seq #(
    .MAX_GRP(MAX_GRP)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .mode (mode_in),
    .ready(row_ready),
    .valid(row_valid),
    .grp  (grp),
    .half (half),
    .last (row_last),
    .load (load)
  );

  acc_rowgen_emit #(
    .ROW_W(ROW_W),
    .GRP_W(GRP_W)
  ) u_emit (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .base_in  (base_c),
    .stride_in(stride_c),
    .grp      (grp),
    .half     (half),
    .row      (row_idx)
  );
endmodule

// File: rtl/acc_rowgen_chk.sv
module acc_rowgen_chk #(
  parameter int ROW_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             row_valid,
  input logic             row_ready,
  input logic [ROW_W-1:0] row_idx,
  input logic             row_last
);
  AST_START_FIRST_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !row_valid) |=> (row_valid && !row_idx[0])); // R2

  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_ready && !row_last && !row_idx[0]) |=>
      (row_valid && row_idx == $past(row_idx) + ROW_W'(1))); // R5

  AST_LAST_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_last) |-> row_idx[0]); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && !row_ready) |=>
      (row_valid && $stable(row_idx) && $stable(row_last))); // R7

  AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (row_valid && row_ready && row_last) |=> !row_valid); // R9
endmodule

bind acc_rowgen acc_rowgen_chk #(
  .ROW_W($clog2(acc_rowgen_pkg::rows_for_vl(VL_BITS)))
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .row_valid(row_valid),
  .row_ready(row_ready),
  .row_idx  (row_idx),
  .row_last (row_last)
);

// File: tb/tb_acc_rowgen.sv
`timescale 1ns/1ps
module tb_acc_rowgen;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] sel_bank = '0;
  logic [1:0]   sel_idx = '0;
  logic         off_bit = 1'b0;
  logic         quad_mode = 1'b0;
  logic         row_valid;
  logic         row_ready = 1'b1;
  logic [3:0]   row_idx;
  logic         row_last;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_rowgen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_bank(sel_bank),
    .sel_idx(sel_idx), .off_bit(off_bit), .quad_mode(quad_mode),
    .row_valid(row_valid), .row_ready(row_ready), .row_idx(row_idx),
    .row_last(row_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input int s, input int o, input int m,
                         input bit stall, input bit intrude);
    logic [31:0] word;
    logic [31:0] sum;
    int n;
    int stride;
    int base;
    int exp;
    word   = sel_bank[s*32 +: 32];
    sum    = word + 32'(2*o);
    n      = (m != 0) ? 4 : 2;
    stride = 16 / n;
    base   = int'(sum % 32'(stride)) & ~1;
    @(negedge clk);
    start = 1'b1; sel_idx = 2'(s); off_bit = o[0]; quad_mode = m[0]; row_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(row_valid == 1'b1, "R2 valid after start", int'(row_valid), 1);
    if (intrude) begin
      sel_idx = ~sel_idx; off_bit = ~off_bit; quad_mode = ~quad_mode;
      sel_bank = ~sel_bank;
    end
    for (int k = 0; k < 2*n; k++) begin
      exp   = base + (k/2)*stride + (k%2);
      start = intrude && (k != 2*n-1);
      if (stall && (k%2 == 1)) begin
        row_ready = 1'b0;
        @(negedge clk);
        chk(row_valid && row_idx == 4'(exp), "R7 stall hold", int'(row_idx), exp);
        row_ready = 1'b1;
      end
      if (k == 0)
        chk(row_idx == 4'(exp), "R3 base row", int'(row_idx), exp);
      else if (k == 2)
        chk(row_idx == 4'(exp), "R4 stride step", int'(row_idx), exp);
      else
        chk(row_idx == 4'(exp), intrude ? "R10 R8 row order" : "R5 row order",
            int'(row_idx), exp);
      chk(row_valid == 1'b1, "R5 valid in sequence", int'(row_valid), 1);
      chk(row_last == (k == 2*n-1), "R6 last flag", int'(row_last), int'(k == 2*n-1));
      @(negedge clk);
    end
    start = 1'b0;
    chk(row_valid == 1'b0, "R9 valid drops", int'(row_valid), 0);
    if (intrude) begin
      sel_bank = ~sel_bank;
      @(negedge clk);
      chk(row_valid == 1'b0, "R8 no extra sequence", int'(row_valid), 0);
    end
  endtask

  initial begin
    logic [31:0] pats [8];
    pats[0] = 32'h0000_0000; pats[1] = 32'h0000_0001;
    pats[2] = 32'h0000_0005; pats[3] = 32'h7FFF_FFF3;
    pats[4] = 32'hFFFF_FFFF; pats[5] = 32'hFFFF_FFFE;
    pats[6] = 32'h1234_567B; pats[7] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    chk(row_valid == 1'b0, "R1 reset idle", int'(row_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(row_valid == 1'b0, "R1 idle without start", int'(row_valid), 0);
    for (int p = 0; p < 8; p++) begin
      for (int j = 0; j < 4; j++)
        sel_bank[j*32 +: 32] = pats[p] ^ 32'(j*9);
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 2; o++)
          for (int m = 0; m < 2; m++)
            run_seq(s, o, m, ((s + o + p) % 2) == 1, (p % 2) == 1);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule